// File: doc/BRIEF.md
# Single-Cell Lithium Charge Cycle Controller

This block is the digital sequencer of a linear single-cell lithium charger. It takes flags from the analog comparators: battery below the low-voltage level, battery below the recharge level, battery at regulation voltage, current below the taper level, current below the termination level, temperature in window, junction too hot and supply present. It also takes two active-low enables and a one-second tick. From these it picks the regulation mode the analog loop applies: off, precharge, constant current or constant voltage. It also drives the status, power-good and fault outputs.

Every asynchronous flag passes through a two-stage synchronizer. Three tick-counted timers guard the cycle: a precharge safety timer, a fast-charge timer and a taper timer. Their lengths are parameters. When a finished or faulted battery sags below the recharge level, the block asks an external battery-presence probe for a verdict through a request/acknowledge pair. A present battery starts a fresh cycle. An absent one parks the controller until the voltage rises again.

Top module: `chg_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (off) and fault_o, stat1_on_o, stat2_on_o and probe_req_o are 0.
- R2: A cycle that starts with the low-voltage flag set enters precharge (mode_o = 1), and one that starts without it enters constant current (mode_o = 2). stat1_on_o is 1 and stat2_on_o is 0 while charging runs.
- R3: If the low-voltage flag stays set for PRE_TICKS unsuspended ticks of precharge, charging stops: mode_o = 0, fault_o = 1 and both status outputs are 0.
- R4: When the low-voltage flag clears during precharge, the block moves to fast charge with a fast-charge timer that starts from zero.
- R5: In fast charge, mode_o is 3 (constant voltage) while the regulation flag is set and 2 otherwise. After FAST_TICKS unsuspended ticks without termination, the block faults as in R3.
- R6: At regulation voltage, current below the termination level ends the cycle at once: mode_o = 0, stat2_on_o = 1, stat1_on_o = 0.
- R7: At regulation voltage, current below the taper level for TAPER_TICKS consecutive ticks ends the cycle as in R6. If the current rises above the taper level, the taper count restarts.
- R8: Temperature out of window or junction overtemperature forces mode_o = 0 and both status outputs to 0. All timers hold their counts, and charging resumes in the same phase when the condition clears.
- R9: While tte_n_i is low, the fast-charge timer and both termination paths work. While it is high, they are disabled. A falling edge on tte_n_i clears all timers.
- R10: ce_n_i high stops charging (mode_o = 0) and clears a fault. A falling edge on ce_n_i starts a new cycle with cleared timers.
- R11: With the supply flag clear, pg_on_o, stat1_on_o, stat2_on_o, fault_o and mode_o are all 0. When the supply returns, pg_on_o = 1 and a new cycle starts.
- R12: A fault remains flagged while the battery stays below the recharge level. The fault is released only after the battery has been above that level and then falls below it.
- R13: From done or a released fault, a battery below the recharge level raises probe_req_o. An acknowledge with probe_absent_i = 0 starts a new cycle. An acknowledge with probe_absent_i = 1 holds all outputs off until the recharge flag clears, and then a new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bat_low_i | input | 1 | Battery below low-voltage (precharge) threshold |
| bat_below_rch_i | input | 1 | Battery below recharge threshold |
| at_vreg_i | input | 1 | Battery at regulation voltage |
| i_below_taper_i | input | 1 | Charge current below taper level |
| i_below_term_i | input | 1 | Charge current below termination level |
| temp_ok_i | input | 1 | Battery temperature inside window |
| tj_hot_i | input | 1 | Junction overtemperature |
| supply_ok_i | input | 1 | Supply above battery voltage |
| ce_n_i | input | 1 | Charge enable, active low |
| tte_n_i | input | 1 | Timer and termination enable, active low |
| tick_i | input | 1 | One-cycle pulse per timer tick |
| probe_ack_i | input | 1 | Battery probe finished (one-cycle pulse) |
| probe_absent_i | input | 1 | Probe verdict, valid with probe_ack_i: battery absent |
| mode_o | output | 2 | 0 off, 1 precharge, 2 constant current, 3 constant voltage |
| fault_o | output | 1 | Timer fault flagged |
| stat1_on_o | output | 1 | Status output 1 transistor on (charging) |
| stat2_on_o | output | 1 | Status output 2 transistor on (done) |
| pg_on_o | output | 1 | Power-good transistor on |
| probe_req_o | output | 1 | Request to the battery-presence probe |

## Verification
The bench suspends precharge partway through its timer and lets many ticks pass. A design that kept counting, or that cleared the count, would fault too early or too late after resume. It toggles the timer enable in mid-precharge and bounces the current above the taper level in mid-taper, where a missing clear shows as an early fault or an early done. It also checks that a precharge fault stays latched while the battery is still low, which a design that probed at once would lose. It then walks the probe handshake both ways, and exercises termination with the timer enable high, where a design with termination still active would finish the cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_PRE = 2'd1,
        MODE_CC  = 2'd2,
        MODE_CV  = 2'd3
    } chg_mode_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_PRE,
        ST_FAST,
        ST_DONE,
        ST_FAULT_LO,
        ST_FAULT_HI,
        ST_PROBE,
        ST_ABSENT
    } chg_state_e;

    typedef struct packed {
        logic bat_low;
        logic below_rch;
        logic at_vreg;
        logic below_taper;
        logic below_term;
        logic temp_ok;
        logic tj_hot;
        logic supply_ok;
        logic ce_n;
        logic tte_n;
    } chg_flags_t;

    localparam int FLAG_W = $bits(chg_flags_t);

    function automatic logic is_charging(chg_state_e s);
        return (s == ST_PRE) || (s == ST_FAST);
    endfunction

    function automatic logic is_fault(chg_state_e s);
        return (s == ST_FAULT_LO) || (s == ST_FAULT_HI);
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
    parameter int LIMIT = 2065
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                    cnt <= '0;
        else if (adv && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

    a_r3_timer_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));

    a_r8_timer_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> cnt == $past(cnt));
endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
    import chg_pkg::*;
#(
    parameter int PRE_TICKS   = 2065,
    parameter int FAST_TICKS  = 20650,
    parameter int TAPER_TICKS = 2065,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bat_low_i,
    input  logic       bat_below_rch_i,
    input  logic       at_vreg_i,
    input  logic       i_below_taper_i,
    input  logic       i_below_term_i,
    input  logic       temp_ok_i,
    input  logic       tj_hot_i,
    input  logic       supply_ok_i,
    input  logic       ce_n_i,
    input  logic       tte_n_i,
    input  logic       tick_i,
    input  logic       probe_ack_i,
    input  logic       probe_absent_i,
    output logic [1:0] mode_o,
    output logic       fault_o,
    output logic       stat1_on_o,
    output logic       stat2_on_o,
    output logic       pg_on_o,
    output logic       probe_req_o
);
    chg_flags_t raw, f;
    logic [FLAG_W-1:0] f_bits;

    assign raw = '{bat_low: bat_low_i, below_rch: bat_below_rch_i,
                   at_vreg: at_vreg_i, below_taper: i_below_taper_i,
                   below_term: i_below_term_i, temp_ok: temp_ok_i,
                   tj_hot: tj_hot_i, supply_ok: supply_ok_i,
                   ce_n: ce_n_i, tte_n: tte_n_i};

    chg_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(f_bits)
    );
    assign f = chg_flags_t'(f_bits);

    // edge detectors on the synchronized enables
    logic ce_q, tte_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q  <= 1'b0;
            tte_q <= 1'b0;
        end else begin
            ce_q  <= f.ce_n;
            tte_q <= f.tte_n;
        end
    end

    logic ce_fall, tte_fall, susp, tte_en, restart, taper_cond;
    assign ce_fall    = ce_q & ~f.ce_n;
    assign tte_fall   = tte_q & ~f.tte_n;
    assign susp       = ~f.temp_ok | f.tj_hot;
    assign tte_en     = ~f.tte_n;
    assign restart    = ~f.supply_ok | f.ce_n | ce_fall;
    assign taper_cond = f.at_vreg & f.below_taper;

    chg_state_e state, nxt;

    // timers
    logic clr_all, pre_exp, fast_exp, taper_exp;
    assign clr_all = restart | tte_fall | (state == ST_START);

    chg_timer #(.LIMIT(PRE_TICKS)) u_pre_tmr (
        .clk(clk), .rst(rst), .clr(clr_all),
        .adv(tick_i & (state == ST_PRE) & ~susp),
        .expired(pre_exp)
    );

    chg_timer #(.LIMIT(FAST_TICKS)) u_fast_tmr (
        .clk(clk), .rst(rst), .clr(clr_all | (state == ST_PRE)),
        .adv(tick_i & (state == ST_FAST) & ~susp & tte_en),
        .expired(fast_exp)
    );

    chg_timer #(.LIMIT(TAPER_TICKS)) u_taper_tmr (
        .clk(clk), .rst(rst),
        .clr(clr_all | ~taper_cond | (state != ST_FAST)),
        .adv(tick_i & (state == ST_FAST) & ~susp & tte_en & taper_cond),
        .expired(taper_exp)
    );

    // cycle sequencer
    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = ST_START;
        end else begin
            unique case (state)
                ST_START: nxt = f.bat_low ? ST_PRE : ST_FAST;
                ST_PRE: begin
                    if (!susp) begin
                        if (!f.bat_low)   nxt = ST_FAST;
                        else if (pre_exp) nxt = ST_FAULT_LO;
                    end
                end
                ST_FAST: begin
                    if (!susp && tte_en) begin
                        if (f.at_vreg && f.below_term) nxt = ST_DONE;
                        else if (taper_exp)            nxt = ST_DONE;
                        else if (fast_exp)             nxt = ST_FAULT_LO;
                    end
                end
                ST_DONE:     if (f.below_rch)  nxt = ST_PROBE;
                ST_FAULT_LO: if (!f.below_rch) nxt = ST_FAULT_HI;
                ST_FAULT_HI: if (f.below_rch)  nxt = ST_PROBE;
                ST_PROBE: begin
                    if (probe_ack_i) nxt = probe_absent_i ? ST_ABSENT : ST_START;
                end
                ST_ABSENT:   if (!f.below_rch) nxt = ST_START;
                default:     nxt = ST_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_START;
        else     state <= nxt;
    end

    // outputs
    chg_mode_e mode;
    always_comb begin
        mode = MODE_OFF;
        if (f.supply_ok && !susp) begin
            if (state == ST_PRE)       mode = MODE_PRE;
            else if (state == ST_FAST) mode = f.at_vreg ? MODE_CV : MODE_CC;
        end
    end

    assign mode_o      = mode;
    assign pg_on_o     = f.supply_ok;
    assign stat1_on_o  = f.supply_ok & is_charging(state) & ~susp;
    assign stat2_on_o  = f.supply_ok & (state == ST_DONE);
    assign fault_o     = f.supply_ok & is_fault(state);
    assign probe_req_o = f.supply_ok & (state == ST_PROBE);

    // checks on the sequencer
    a_r11_sleep_restarts: assert property (@(posedge clk) disable iff (rst)
        !f.supply_ok |=> state == ST_START);

    a_r10_ce_holds_start: assert property (@(posedge clk) disable iff (rst)
        f.ce_n |=> state == ST_START);

    a_r8_suspend_freezes: assert property (@(posedge clk) disable iff (rst)
        (susp && is_charging(state) && !restart) |=> state == $past(state));

    a_r3_fault_from_timer: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT_LO && $past(state) != ST_FAULT_LO)
            |-> ($past(pre_exp) || $past(fast_exp)));

    a_r9_done_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && $past(state) == ST_FAST) |-> $past(tte_en));

    a_r12_fault_held_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT_LO && f.below_rch && !restart) |=> state == ST_FAULT_LO);
endmodule

// File: tb/chg_ctrl_bench.sv
`timescale 1ns/1ps
module chg_ctrl_bench;
    localparam int PRE   = 8;
    localparam int FAST  = 40;
    localparam int TAPER = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bat_low = 0, below_rch = 0, at_vreg = 0, below_taper = 0, below_term = 0;
    logic temp_ok = 1, tj_hot = 0, supply_ok = 1, ce_n = 0, tte_n = 0;
    logic tick = 0, probe_ack = 0, probe_absent = 0;
    logic [1:0] mode;
    logic fault, stat1, stat2, pg, probe_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    chg_ctrl #(.PRE_TICKS(PRE), .FAST_TICKS(FAST), .TAPER_TICKS(TAPER)) u_chg_ctrl (
        .clk(clk), .rst(rst),
        .bat_low_i(bat_low), .bat_below_rch_i(below_rch), .at_vreg_i(at_vreg),
        .i_below_taper_i(below_taper), .i_below_term_i(below_term),
        .temp_ok_i(temp_ok), .tj_hot_i(tj_hot), .supply_ok_i(supply_ok),
        .ce_n_i(ce_n), .tte_n_i(tte_n), .tick_i(tick),
        .probe_ack_i(probe_ack), .probe_absent_i(probe_absent),
        .mode_o(mode), .fault_o(fault), .stat1_on_o(stat1), .stat2_on_o(stat2),
        .pg_on_o(pg), .probe_req_o(probe_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic defaults();
        bat_low = 0; below_rch = 0; at_vreg = 0; below_taper = 0; below_term = 0;
        temp_ok = 1; tj_hot = 0; supply_ok = 1; tte_n = 0;
    endtask

    task automatic new_cycle();
        ce_n = 1'b1;
        settle();
        ce_n = 1'b0;
        settle();
    endtask

    task automatic ack(input logic absent);
        probe_absent = absent;
        probe_ack = 1'b1;
        @(negedge clk);
        probe_ack = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mode", mode, 0);
        check("R1 fault", fault, 0);
        check("R1 stat1", stat1, 0);
        check("R1 stat2", stat2, 0);
        check("R1 probe", probe_req, 0);
        settle();
        check("R11 pg with supply", pg, 1);
        check("R2 start in cc", mode, 2);
        check("R2 stat1 on", stat1, 1);
    endtask

    task automatic t_pre_fault();
        defaults(); bat_low = 1; below_rch = 1;
        new_cycle();
        check("R2 precharge mode", mode, 1);
        check("R2 stat2 off", stat2, 0);
        ticks(PRE - 1);
        check("R3 before expiry", mode, 1);
        ticks(1);
        settle();
        check("R3 fault set", fault, 1);
        check("R3 mode off", mode, 0);
        check("R3 stat1 off", stat1, 0);
        check("R12 no probe while low", probe_req, 0);
        bat_low = 0; below_rch = 0;
        settle();
        check("R12 fault above rch", fault, 1);
        below_rch = 1;
        settle();
        check("R13 probe req", probe_req, 1);
        check("R12 fault released", fault, 0);
        below_rch = 0;
        ack(1'b0);
        check("R13 present restarts", mode, 2);
    endtask

    task automatic t_pre_to_fast();
        defaults(); bat_low = 1; below_rch = 1;
        new_cycle();
        ticks(5);
        bat_low = 0; below_rch = 0;
        settle();
        check("R4 to fast", mode, 2);
        at_vreg = 1;
        settle();
        check("R5 cv mode", mode, 3);
        at_vreg = 0;
        settle();
        ticks(FAST - 1);
        check("R4 fresh fast timer", fault, 0);
        ticks(1);
        settle();
        check("R5 fast timeout", fault, 1);
    endtask

    task automatic t_term();
        defaults();
        new_cycle();
        at_vreg = 1; below_term = 1;
        settle();
        check("R6 done stat2", stat2, 1);
        check("R6 stat1 off", stat1, 0);
        check("R6 mode off", mode, 0);
        tte_n = 1;
        new_cycle();
        check("R9 term ignored", mode, 3);
        below_taper = 1;
        ticks(FAST + 5);
        check("R9 no timeout", fault, 0);
        check("R9 no done", stat2, 0);
    endtask

    task automatic t_taper();
        defaults();
        new_cycle();
        at_vreg = 1; below_taper = 1;
        settle();
        ticks(4);
        below_taper = 0;
        settle();
        below_taper = 1;
        settle();
        ticks(TAPER - 1);
        check("R7 taper restarted", mode, 3);
        ticks(1);
        settle();
        check("R7 taper done", stat2, 1);
    endtask

    task automatic t_suspend();
        defaults(); bat_low = 1; below_rch = 1;
        new_cycle();
        ticks(5);
        temp_ok = 0;
        settle();
        check("R8 mode off", mode, 0);
        check("R8 stat1 off", stat1, 0);
        ticks(20);
        check("R8 no fault", fault, 0);
        temp_ok = 1;
        settle();
        check("R8 resume pre", mode, 1);
        ticks(2);
        tj_hot = 1;
        settle();
        check("R8 hot off", mode, 0);
        ticks(10);
        tj_hot = 0;
        settle();
        check("R8 resume again", mode, 1);
        ticks(1);
        settle();
        check("R8 held count", fault, 1);
    endtask

    task automatic t_tte_reset();
        defaults(); bat_low = 1; below_rch = 1;
        new_cycle();
        ticks(5);
        tte_n = 1;
        settle();
        tte_n = 0;
        settle();
        ticks(PRE - 1);
        check("R9 timers cleared", mode, 1);
        ticks(1);
        settle();
        check("R9 fault after full", fault, 1);
    endtask

    task automatic t_ce();
        ce_n = 1;
        settle();
        check("R10 fault cleared", fault, 0);
        check("R10 mode off", mode, 0);
        ticks(PRE + 2);
        check("R10 stays off", mode, 0);
        ce_n = 0;
        settle();
        check("R10 new cycle", mode, 1);
        check("R10 no fault", fault, 0);
    endtask

    task automatic t_sleep();
        supply_ok = 0;
        settle();
        check("R11 pg off", pg, 0);
        check("R11 stat1 off", stat1, 0);
        check("R11 mode off", mode, 0);
        supply_ok = 1;
        settle();
        check("R11 pg back", pg, 1);
        check("R11 restarts", mode, 1);
    endtask

    task automatic t_recharge();
        defaults();
        new_cycle();
        at_vreg = 1; below_term = 1;
        settle();
        check("R6 done", stat2, 1);
        at_vreg = 0; below_term = 0; below_rch = 1;
        settle();
        check("R13 probe from done", probe_req, 1);
        check("R13 stat2 off", stat2, 0);
        ack(1'b1);
        check("R13 absent mode", mode, 0);
        check("R13 absent stat1", stat1, 0);
        check("R13 absent stat2", stat2, 0);
        check("R13 absent probe", probe_req, 0);
        below_rch = 0;
        settle();
        check("R13 absent restart", mode, 2);
    endtask

    initial begin
        t_reset();
        t_pre_fault();
        t_pre_to_fast();
        t_term();
        t_taper();
        t_suspend();
        t_tte_reset();
        t_ce();
        t_sleep();
        t_recharge();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule